// File: doc/BRIEF.md
# Second-Order Recursive Filter with Start/Done Handshake

This block is a fixed-point biquad: every accepted input sample produces one output sample equal to a weighted sum of the current input and the two inputs before it, less weighted copies of the two previous outputs. Five coefficients are fixed at elaboration time. Samples and coefficients are signed fixed-point numbers (by default 16 bits with 14 fraction bits). The products are summed at full precision, then rounded once and clamped to the sample width.

The surrounding logic offers a sample with `start`. The block reports that it can take one with `ready`, shows that nothing is in flight with `idle`, and marks each result with a one-cycle `done`. A mode parameter picks one of two builds. The streaming build takes a sample on every clock. The sequential build takes one sample every three clocks and drops any `start` raised while it is busy. In both builds the result appears two cycles after acceptance. The streaming build keeps that latency with the recursion closing every cycle: it moves the older output term into the first stage, so only the newest-output product and the final sum remain in the one-cycle loop.

Top module: `iir2_biquad`

## Requirements
- R1: For an accepted sample x[n] the result is sat(round(B0·x[n] + B1·x[n-1] + B2·x[n-2] − A1·y[n-1] − A2·y[n-2])). Here round adds 2^(FRAC_W−1) and then shifts right arithmetically by FRAC_W, and the sum is exact before rounding.
- R2: The history holds the two most recent accepted inputs and the two most recent results. It advances only on accepted samples, and every older entry moves back by one.
- R3: A sample accepted at a rising edge (`start` and `ready` both high) drives `done` high and puts its result on `y_out` after the following rising edge, two cycles after it was presented.
- R4: In the streaming build `ready` is always 1 and every cycle with `start` high is accepted, so back-to-back samples give back-to-back results.
- R5: In the sequential build `ready` drops for the two cycles after an acceptance and returns in the third. A `start` seen while `ready` is 0 is dropped and changes neither the outputs nor the history.
- R6: `done` is high for exactly one cycle per accepted sample. While `done` is low, `y_out` keeps the last result.
- R7: `idle` is 1 exactly when no sample was accepted in the previous two cycles. In the sequential build `ready` equals `idle`.
- R8: While `rst_n` is low the history and `y_out` are 0, `done` is 0 and `idle` is 1. A sample in flight when reset is asserted is discarded.
- R9: A rounded sum above 2^(DATA_W−1)−1 gives exactly 2^(DATA_W−1)−1 (32767 by default). A sum below −2^(DATA_W−1) gives exactly −2^(DATA_W−1) (−32768 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Offers `x_in` as the next sample |
| x_in | input | DATA_W | Signed input sample |
| ready | output | 1 | Block takes `start` in this cycle |
| done | output | 1 | `y_out` carries a new result in this cycle |
| idle | output | 1 | No sample in flight |
| y_out | output | DATA_W | Signed result of the last completed sample |

## Verification
A wrong history entry changes every later result, so it shows on `y_out` at the first `done` after the entry is used, two cycles after the sample that reads it. A wrong value in the older-output path of the streaming build shows only in back-to-back runs or runs with one-cycle gaps. The bench therefore mixes dense, gapped and isolated samples, and compares the results bit for bit with an integer model. Control faults show on `done`, `idle` and `ready` in the cycle they happen, so these outputs are compared with a model of the acceptance timing on every cycle.

// File: rtl/iir2_pkg.sv
package iir2_pkg;

  // Build variant: one sample per three cycles, or one per cycle.
  typedef enum logic {
    MODE_SEQ  = 1'b0,
    MODE_PIPE = 1'b1
  } mode_e;

endpackage

// File: rtl/iir2_ctrl.sv
module iir2_ctrl
  import iir2_pkg::*;
#(
  parameter mode_e MODE = MODE_PIPE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic s1_vld,
  output logic done,
  output logic ready,
  output logic idle
);

  logic s1_vld_q, s1_vld_d;
  logic done_q, done_d;

  assign idle = ~s1_vld_q & ~done_q;

  generate
    if (MODE == MODE_PIPE) begin : g_stream
      assign ready = 1'b1;
    end else begin : g_serial
      assign ready = idle;
    end
  endgenerate

  assign accept = start & ready;

  always_comb begin
    s1_vld_d = accept;
    done_d   = s1_vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      s1_vld_q <= s1_vld_d;
      done_q   <= done_d;
    end
  end

  assign s1_vld = s1_vld_q;
  assign done   = done_q;

endmodule

// File: rtl/iir2_ff_stage.sv
module iir2_ff_stage
  import iir2_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned ACC_W  = 35,
  parameter mode_e       MODE   = MODE_PIPE,
  parameter logic signed [COEF_W-1:0] B0 = '0,
  parameter logic signed [COEF_W-1:0] B1 = '0,
  parameter logic signed [COEF_W-1:0] B2 = '0,
  parameter logic signed [COEF_W-1:0] A2 = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept,
  input  logic                     inflight,
  input  logic signed [DATA_W-1:0] x_in,
  input  logic signed [DATA_W-1:0] y1,
  input  logic signed [DATA_W-1:0] y2,
  output logic signed [ACC_W-1:0]  psum
);

  localparam int unsigned PROD_W = DATA_W + COEF_W;

  logic signed [DATA_W-1:0] x1_q, x2_q;
  logic signed [PROD_W-1:0] pb0, pb1, pb2;
  logic signed [ACC_W-1:0]  ff_sum, psum_d, psum_q;

  always_comb begin
    pb0    = PROD_W'(B0) * PROD_W'(x_in);
    pb1    = PROD_W'(B1) * PROD_W'(x1_q);
    pb2    = PROD_W'(B2) * PROD_W'(x2_q);
    ff_sum = ACC_W'(pb0) + ACC_W'(pb1) + ACC_W'(pb2);
  end

  generate
    if (MODE == MODE_PIPE) begin : g_stream
      // Older output term leaves the loop: pick y[n-2] by what is in flight.
      logic signed [DATA_W-1:0] y_old;
      logic signed [PROD_W-1:0] pa2;
      always_comb begin
        y_old  = inflight ? y1 : y2;
        pa2    = PROD_W'(A2) * PROD_W'(y_old);
        psum_d = ff_sum - ACC_W'(pa2);
      end
    end else begin : g_serial
      always_comb psum_d = ff_sum;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x1_q   <= '0;
      x2_q   <= '0;
      psum_q <= '0;
    end else if (accept) begin
      x2_q   <= x1_q;
      x1_q   <= x_in;
      psum_q <= psum_d;
    end
  end

  assign psum = psum_q;

endmodule

// File: rtl/iir2_fb_stage.sv
module iir2_fb_stage #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned FRAC_W = 14,
  parameter int unsigned ACC_W  = 35,
  parameter logic signed [COEF_W-1:0] A1 = '0,
  parameter logic signed [COEF_W-1:0] A2 = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s1_vld,
  input  logic signed [ACC_W-1:0]  psum,
  output logic signed [DATA_W-1:0] y1,
  output logic signed [DATA_W-1:0] y2
);

  localparam int unsigned PROD_W = DATA_W + COEF_W;
  localparam logic signed [ACC_W-1:0] RND_HALF = ACC_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [ACC_W-1:0] SAT_HI =
    {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SAT_LO =
    {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic signed [DATA_W-1:0] y1_q, y1_d, y2_q, y2_d;
  logic signed [PROD_W-1:0] pa1, pa2;
  logic signed [ACC_W-1:0]  acc, shifted;
  logic signed [DATA_W-1:0] y_new;

  always_comb begin
    pa1     = PROD_W'(A1) * PROD_W'(y1_q);
    pa2     = PROD_W'(A2) * PROD_W'(y2_q);
    acc     = psum - ACC_W'(pa1) - ACC_W'(pa2);
    shifted = (acc + RND_HALF) >>> FRAC_W;
    if (shifted > SAT_HI) begin
      y_new = SAT_HI[DATA_W-1:0];
    end else if (shifted < SAT_LO) begin
      y_new = SAT_LO[DATA_W-1:0];
    end else begin
      y_new = shifted[DATA_W-1:0];
    end
    y1_d = s1_vld ? y_new : y1_q;
    y2_d = s1_vld ? y1_q  : y2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y1_q <= '0;
      y2_q <= '0;
    end else begin
      y1_q <= y1_d;
      y2_q <= y2_d;
    end
  end

  assign y1 = y1_q;
  assign y2 = y2_q;

endmodule

// File: rtl/iir2_biquad.sv
module iir2_biquad
  import iir2_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned FRAC_W = 14,
  parameter mode_e       MODE   = MODE_PIPE,
  parameter logic signed [COEF_W-1:0] B0 = COEF_W'(4096),
  parameter logic signed [COEF_W-1:0] B1 = COEF_W'(8192),
  parameter logic signed [COEF_W-1:0] B2 = COEF_W'(4096),
  parameter logic signed [COEF_W-1:0] A1 = COEF_W'(-19661),
  parameter logic signed [COEF_W-1:0] A2 = COEF_W'(8192)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic signed [DATA_W-1:0] x_in,
  output logic                     ready,
  output logic                     done,
  output logic                     idle,
  output logic signed [DATA_W-1:0] y_out
);

  localparam int unsigned ACC_W = DATA_W + COEF_W + 3;
  // In the streaming build the older output term is folded into stage one.
  localparam logic signed [COEF_W-1:0] A2_LOOP = (MODE == MODE_PIPE) ? '0 : A2;

  logic                     accept;
  logic                     s1_vld;
  logic signed [ACC_W-1:0]  psum;
  logic signed [DATA_W-1:0] y1, y2;

  iir2_ctrl #(
    .MODE (MODE)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .accept (accept),
    .s1_vld (s1_vld),
    .done   (done),
    .ready  (ready),
    .idle   (idle)
  );

  iir2_ff_stage #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .ACC_W  (ACC_W),
    .MODE   (MODE),
    .B0     (B0),
    .B1     (B1),
    .B2     (B2),
    .A2     (A2)
  ) u_ff (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .inflight (s1_vld),
    .x_in     (x_in),
    .y1       (y1),
    .y2       (y2),
    .psum     (psum)
  );

  iir2_fb_stage #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .FRAC_W (FRAC_W),
    .ACC_W  (ACC_W),
    .A1     (A1),
    .A2     (A2_LOOP)
  ) u_fb (
    .clk    (clk),
    .rst_n  (rst_n),
    .s1_vld (s1_vld),
    .psum   (psum),
    .y1     (y1),
    .y2     (y2)
  );

  assign y_out = y1;

endmodule

// File: rtl/iir2_biquad_chk.sv
module iir2_biquad_chk #(
  parameter int unsigned DATA_W = 16,
  parameter bit          SEQ    = 1'b0
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic                     ready,
  input logic                     done,
  input logic                     idle,
  input logic signed [DATA_W-1:0] y_out
);

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |-> ##2 done);

  assert_done_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start && ready, 2));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(y_out));

  assert_busy_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (SEQ && start && ready) |=> !ready ##1 !ready ##1 ready);

  assert_stream_rate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!SEQ && start) |-> ##2 done);

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> !idle);

  assert_idle_no_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !done);

endmodule

bind iir2_biquad iir2_biquad_chk #(
  .DATA_W (DATA_W),
  .SEQ    (MODE == iir2_pkg::MODE_SEQ)
) u_iir2_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .ready (ready),
  .done  (done),
  .idle  (idle),
  .y_out (y_out)
);

// File: tb/test_iir2_biquad.sv
`timescale 1ns/1ps
module test_iir2_biquad;
  import iir2_pkg::*;

  localparam int DW  = 16;
  localparam int CB0 = 4096;
  localparam int CB1 = 8192;
  localparam int CB2 = 4096;
  localparam int CA1 = -19661;
  localparam int CA2 = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic signed [DW-1:0] x_in = '0;
  logic rdy [2];
  logic dn  [2];
  logic idl [2];
  logic signed [DW-1:0] yo [2];

  always #4 clk = ~clk;

  // Channel 0: streaming build, channel 1: sequential build.
  iir2_biquad #(.DATA_W(DW), .COEF_W(16), .FRAC_W(14), .MODE(MODE_PIPE),
    .B0(16'(CB0)), .B1(16'(CB1)), .B2(16'(CB2)), .A1(16'(CA1)), .A2(16'(CA2)))
  i_iir2_biquad (.clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in),
    .ready(rdy[0]), .done(dn[0]), .idle(idl[0]), .y_out(yo[0]));

  iir2_biquad #(.DATA_W(DW), .COEF_W(16), .FRAC_W(14), .MODE(MODE_SEQ),
    .B0(16'(CB0)), .B1(16'(CB1)), .B2(16'(CB2)), .A1(16'(CA1)), .A2(16'(CA2)))
  i_iir2_biquad_seq (.clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in),
    .ready(rdy[1]), .done(dn[1]), .idle(idl[1]), .y_out(yo[1]));

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 1'b0;
  bit post_rst = 1'b0;
  int unsigned lfsr = 32'h1234_5678;

  longint mx1 [2], mx2 [2], my1 [2], my2 [2];
  longint ey_r [2][4];
  bit     acc_r [2][4];
  longint last_y [2];

  function automatic longint model(int ch, longint x);
    longint a;
    a = CB0 * x + CB1 * mx1[ch] + CB2 * mx2[ch] - CA1 * my1[ch] - CA2 * my2[ch];
    a = (a + 8192) >>> 14;
    if (a > 32767) a = 32767;
    else if (a < -32768) a = -32768;
    mx2[ch] = mx1[ch];
    mx1[ch] = x;
    my2[ch] = my1[ch];
    my1[ch] = a;
    return a;
  endfunction

  function automatic int unsigned next_rand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  task automatic chk(string tag, int ch, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s ch%0d cycle %0d actual=%0d expected=%0d", tag, ch, cyc, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int ch = 0; ch < 2; ch++) begin
      mx1[ch] = 0; mx2[ch] = 0; my1[ch] = 0; my2[ch] = 0; last_y[ch] = 0;
      for (int k = 0; k < 4; k++) begin
        acc_r[ch][k] = 1'b0;
        ey_r[ch][k]  = 0;
      end
    end
  endtask

  // One cycle: check the outputs, then present the next input.
  task automatic step(bit st, longint xv);
    @(negedge clk);
    cyc++;
    for (int ch = 0; ch < 2; ch++) begin
      bit de, ie, re;
      longint ey;
      de = acc_r[ch][(cyc - 2) & 3];
      ie = !acc_r[ch][(cyc - 1) & 3] && !de;
      re = (ch == 0) ? 1'b1 : ie;
      ey = ey_r[ch][(cyc - 2) & 3];
      chk(post_rst ? "R8 done after reset" : "R3 R6 done timing", ch, longint'(dn[ch]), longint'(de));
      chk(post_rst ? "R8 idle after reset" : "R7 idle", ch, longint'(idl[ch]), longint'(ie));
      chk((ch == 0) ? "R4 ready stream" : "R5 ready serial", ch, longint'(rdy[ch]), longint'(re));
      if (de) begin
        chk((ey == 32767 || ey == -32768) ? "R9 saturated result" : "R1 R2 result",
            ch, longint'(yo[ch]), ey);
        last_y[ch] = ey;
      end else begin
        chk(post_rst ? "R8 output after reset" : "R6 output hold", ch, longint'(yo[ch]), last_y[ch]);
      end
      acc_r[ch][cyc & 3] = st && re;
      if (st && re) ey_r[ch][cyc & 3] = model(ch, xv);
    end
    post_rst = 1'b0;
    start = st;
    x_in  = xv[DW-1:0];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start = 1'b0;
    x_in  = '0;
    repeat (3) @(negedge clk);
    clear_model();
    rst_n = 1'b1;
    post_rst = 1'b1;
  endtask

  initial begin
    clear_model();
    do_reset();
    repeat (3) step(1'b0, 0);

    // Impulse, start held high: serial build drops the busy starts (R5).
    step(1'b1, 16384);
    repeat (24) step(1'b1, 0);
    repeat (4) step(1'b0, 0);

    // Random samples with random gaps (R1 R2 R4 R5).
    repeat (400) begin
      int unsigned r;
      r = next_rand();
      step(r[0], longint'($signed(r[31:16])));
    end
    repeat (4) step(1'b0, 0);

    // Full-scale steps drive both clamps (R9).
    repeat (60) step(1'b1, 32767);
    repeat (4) step(1'b0, 0);
    repeat (60) step(1'b1, -32768);
    repeat (4) step(1'b0, 0);

    // Reset with samples in flight, then an impulse from clean state (R8).
    repeat (5) step(1'b1, 20000);
    do_reset();
    step(1'b1, 16384);
    repeat (12) step(1'b1, 0);
    repeat (4) step(1'b0, 0);

    // Sweep of the input range, dense.
    for (int v = -32768; v < 32768; v += 257) step(1'b1, longint'(v));
    repeat (4) step(1'b0, 0);

    // One-cycle gaps: the streaming build must pick the older output (R2 R4).
    for (int k = 0; k < 300; k++) begin
      int unsigned r;
      r = next_rand();
      step(k[0] == 1'b0, longint'($signed(r[15:0])));
    end
    repeat (4) step(1'b0, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog R3 actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule